// File: doc/BRIEF.md
# 64-bit Match-Compare System Timer

This block is a memory-mapped system timer on a plain 32-bit register bus. It has a single write strobe and a combinational read port. A programmable prescaler divides the input clock and paces a free-running 64-bit up-counter. Software can preset either half of that counter at any time.

Six 32-bit compare channels watch the low word of the counter. When the counter steps onto a channel's value, the channel raises a sticky status flag. Software clears a flag by writing a 1 to it. Each flag has an enable mask bit, and the masked flags are ORed into one level interrupt. The last compare channel can also serve as a watchdog: when armed, its match emits a one-cycle reset-request pulse.

Because the counter is wider than the bus, software reads it through a snapshot. A write to the snapshot command copies all 64 bits into two holding words in one cycle. Software can then read the two halves at leisure without tearing.

Top module: `sys_timer64`

## Requirements
- R1: After reset the counter, divider, all compare values, status flags, interrupt enables and watchdog arm bit are zero, and both `irq` and `wdog_rst_req` are low.
- R2: The counter advances by one every 2*(D+1) clock cycles, where D is the divider value. A write to the divider or to either counter word restarts the prescaler phase. An increment from all-ones in the low word carries into the high word.
- R3: Writing a word with bit 0 set to the snapshot command (byte offset 0x30) copies the full 64-bit count into the snapshot words in that cycle. The snapshot words hold their value until the next such write, and the command offset reads as zero.
- R4: The counter low word (0x00) and high word (0x04) can each be written. A write replaces only that half, and the write takes priority over a prescaler step in the same cycle.
- R5: A channel n sets status bit n only when the counter has just stepped (not been written) to a low word equal to its compare value. The flag becomes visible one cycle after the step. Holding on that value does not set it again.
- R6: Writing to the status word (0x20) clears every flag whose data bit is 1 and leaves the flags whose data bit is 0. A new match in the same cycle wins over the clear.
- R7: `irq` is high exactly while some status bit n and its enable bit n (word 0x24) are both 1.
- R8: When bit 0 of the watchdog arm word (0x28) is 1, a match on channel 5 drives `wdog_rst_req` high for exactly one cycle, in the same cycle that status bit 5 becomes visible. With the arm bit at 0, no pulse is produced.
- R9: Byte offsets are word-aligned and address bits [1:0] are ignored. Compare n sits at 0x08+4n, the divider at 0x2C, the snapshot low word at 0x34 and the snapshot high word at 0x38. Status and enable bit n belong to channel n. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of enabled status flags |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The counter is swept over four divider settings, with wait lengths from zero to nine cycles. Each case is compared against the arithmetic count formula through the snapshot path, which separates a wrong prescaler period from a missing phase restart. A carry test across the low-word boundary lands on zero and so fires every channel still holding the reset compare value. Each channel is also fired alone and checked against matching and non-matching enable masks, which exposes crossed channel indices. Cycle-exact probes around a match tell a flag raised on the counter step apart from one raised while the counter holds. The same probes tell a one-cycle watchdog pulse apart from a stretched or missing one, and they show that armed and disarmed watchdogs differ.

// File: rtl/sys_timer64_pkg.sv
`timescale 1ns/1ps
package sys_timer64_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_MATCH = 6;

   // word indices (byte offset / 4)
   localparam int unsigned W_CNT_LO  = 0;
   localparam int unsigned W_CNT_HI  = 1;
   localparam int unsigned W_MATCH0  = 2;
   localparam int unsigned W_STATUS  = 8;
   localparam int unsigned W_INT_EN  = 9;
   localparam int unsigned W_WDOG_EN = 10;
   localparam int unsigned W_DIV     = 11;
   localparam int unsigned W_LATCH   = 12;
   localparam int unsigned W_LAT_LO  = 13;
   localparam int unsigned W_LAT_HI  = 14;

   typedef struct packed {
      logic cnt_lo;
      logic cnt_hi;
      logic status;
      logic int_en;
      logic wdog_en;
      logic div;
      logic latch;
   } wr_strobe_t;

endpackage

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
// Divides the clock: one tick every 2*(div+1) cycles; restart zeroes the phase.
module timer_prescaler #(
   parameter int unsigned DIV_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int unsigned PS_W = DIV_W + 1;

   logic [PS_W-1:0] phase_q;
   logic [PS_W-1:0] limit;

   assign limit = {div, 1'b1};
   assign tick  = (phase_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/timer_counter64.sv
`timescale 1ns/1ps
// Free-running double-word counter with per-half preset; adv flags a real step.
module timer_counter64 #(
   parameter int unsigned HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [HALF_W-1:0]   wdata,
   output logic [2*HALF_W-1:0] count,
   output logic                adv
);
   logic any_wr;
   assign any_wr = wr_lo | wr_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         adv   <= 1'b0;
      end else begin
         adv <= tick & ~any_wr;
         if (any_wr) begin
            if (wr_lo) count[HALF_W-1:0]        <= wdata;
            if (wr_hi) count[2*HALF_W-1:HALF_W] <= wdata;
         end else if (tick) begin
            count <= count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/timer_match_bank.sv
`timescale 1ns/1ps
// Compare registers; an event fires when the counter has just stepped onto the value.
module timer_match_bank #(
   parameter int unsigned CH = 6,
   parameter int unsigned W  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] we,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  cnt_lo,
   input  logic          adv,
   output logic [W-1:0]  match_q [CH],
   output logic [CH-1:0] evt
);
   for (genvar g = 0; g < CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_q[g] <= '0;
         end else if (we[g]) begin
            match_q[g] <= wdata;
         end
      end
      assign evt[g] = adv && (cnt_lo == match_q[g]);
   end
endmodule

// File: rtl/timer_status.sv
`timescale 1ns/1ps
// Sticky flags, write-one-to-clear, set wins; masked OR forms the interrupt.
module timer_status #(
   parameter int unsigned CH = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] evt,
   input  logic          clr_we,
   input  logic [CH-1:0] clr_mask,
   input  logic [CH-1:0] ie,
   output logic [CH-1:0] status_q,
   output logic          irq
);
   logic [CH-1:0] clr_bits;
   assign clr_bits = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= (status_q & ~clr_bits) | evt;
      end
   end

   assign irq = |(status_q & ie);
endmodule

// File: rtl/sys_timer64.sv
`timescale 1ns/1ps
module sys_timer64
   import sys_timer64_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DIV_W    = 32,
   parameter int unsigned MATCH_CH = 6,
   parameter bit          HAS_WDOG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              wdog_rst_req
);
   localparam int unsigned CNT_W   = 2 * WORD_W;
   localparam int unsigned WDOG_CH = MATCH_CH - 1;

   // elaboration-time parameter checks
   if (MATCH_CH < 1 || MATCH_CH > MAX_MATCH) begin : g_bad_match_ch
      $error("sys_timer64: MATCH_CH out of range");
   end
   if (DIV_W < 1 || DIV_W > WORD_W) begin : g_bad_div_w
      $error("sys_timer64: DIV_W out of range");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("sys_timer64: ADDR_W too small for the register map");
   end

   // address decode
   int unsigned   widx;
   logic          unused_addr_bits;
   wr_strobe_t    wstb;
   logic [MATCH_CH-1:0] match_we;

   assign widx             = int'(bus_addr[ADDR_W-1:2]);
   assign unused_addr_bits = ^bus_addr[1:0];

   always_comb begin
      wstb         = '0;
      wstb.cnt_lo  = bus_wen && (widx == W_CNT_LO);
      wstb.cnt_hi  = bus_wen && (widx == W_CNT_HI);
      wstb.status  = bus_wen && (widx == W_STATUS);
      wstb.int_en  = bus_wen && (widx == W_INT_EN);
      wstb.wdog_en = bus_wen && (widx == W_WDOG_EN);
      wstb.div     = bus_wen && (widx == W_DIV);
      wstb.latch   = bus_wen && (widx == W_LATCH);
      for (int i = 0; i < MATCH_CH; i++) begin
         match_we[i] = bus_wen && (widx == W_MATCH0 + i);
      end
   end

   // control registers
   logic [DIV_W-1:0]    div_q;
   logic [MATCH_CH-1:0] ie_q;
   logic                wden_q;
   logic [CNT_W-1:0]    latched_q;
   logic                latch_we;

   logic                tick;
   logic                cnt_wr_lo;
   logic                cnt_wr_hi;
   logic                cnt_wr;
   logic                status_wr;
   logic [CNT_W-1:0]    count;
   logic                adv;
   logic [WORD_W-1:0]   match_q [MATCH_CH];
   logic [MATCH_CH-1:0] evt;
   logic [MATCH_CH-1:0] status_q;

   assign cnt_wr_lo = wstb.cnt_lo;
   assign cnt_wr_hi = wstb.cnt_hi;
   assign cnt_wr    = cnt_wr_lo | cnt_wr_hi;
   assign status_wr = wstb.status;
   assign latch_we  = wstb.latch && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         ie_q      <= '0;
         wden_q    <= 1'b0;
         latched_q <= '0;
      end else begin
         if (wstb.div)     div_q  <= bus_wdata[DIV_W-1:0];
         if (wstb.int_en)  ie_q   <= bus_wdata[MATCH_CH-1:0];
         if (wstb.wdog_en) wden_q <= bus_wdata[0];
         if (latch_we)     latched_q <= count;
      end
   end

   timer_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wstb.div | cnt_wr),
      .div     (div_q),
      .tick    (tick)
   );

   timer_counter64 #(.HALF_W(WORD_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wr_lo (cnt_wr_lo),
      .wr_hi (cnt_wr_hi),
      .wdata (bus_wdata),
      .count (count),
      .adv   (adv)
   );

   timer_match_bank #(.CH(MATCH_CH), .W(WORD_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (match_we),
      .wdata   (bus_wdata),
      .cnt_lo  (count[WORD_W-1:0]),
      .adv     (adv),
      .match_q (match_q),
      .evt     (evt)
   );

   timer_status #(.CH(MATCH_CH)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_we   (status_wr),
      .clr_mask (bus_wdata[MATCH_CH-1:0]),
      .ie       (ie_q),
      .status_q (status_q),
      .irq      (irq)
   );

   // watchdog variant
   if (HAS_WDOG) begin : g_wdog
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= evt[WDOG_CH] & wden_q;
      end
      assign wdog_rst_req = req_q;
   end else begin : g_no_wdog
      assign wdog_rst_req = 1'b0;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (widx)
         W_CNT_LO:  bus_rdata = count[WORD_W-1:0];
         W_CNT_HI:  bus_rdata = count[CNT_W-1:WORD_W];
         W_STATUS:  bus_rdata = WORD_W'(status_q);
         W_INT_EN:  bus_rdata = WORD_W'(ie_q);
         W_WDOG_EN: bus_rdata = WORD_W'(wden_q);
         W_DIV:     bus_rdata = WORD_W'(div_q);
         W_LAT_LO:  bus_rdata = latched_q[WORD_W-1:0];
         W_LAT_HI:  bus_rdata = latched_q[CNT_W-1:WORD_W];
         default: begin
            for (int i = 0; i < MATCH_CH; i++) begin
               if (widx == W_MATCH0 + i) bus_rdata = match_q[i];
            end
         end
      endcase
   end
endmodule

// File: rtl/sys_timer64_chk.sv
`timescale 1ns/1ps
module sys_timer64_chk #(
   parameter int unsigned MATCH_CH = 6,
   parameter int unsigned WDOG_CH  = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                cnt_wr,
   input logic                cnt_wr_lo,
   input logic [31:0]         bus_wdata,
   input logic [63:0]         count,
   input logic                adv,
   input logic [MATCH_CH-1:0] evt,
   input logic [MATCH_CH-1:0] status_q,
   input logic                status_wr,
   input logic                latch_we,
   input logic [63:0]         latched_q,
   input logic                irq,
   input logic                wdog_rst_req
);
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr) |=> (count == $past(count) + 64'd1));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> (count == $past(count)));

   a_r4_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_lo |=> (count[31:0] == $past(bus_wdata)));

   a_r3_snap: assert property (@(posedge clk) disable iff (!rst_n)
      latch_we |=> (latched_q == $past(count)));

   a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_we |=> $stable(latched_q));

   a_r5_set_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q)) != '0) |-> $past(adv));

   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && bus_wdata[0] && !evt[0]) |=> !status_q[0]);

   a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status_q != '0));

   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |=> !wdog_rst_req);

   a_r8_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |-> status_q[WDOG_CH]);
endmodule

bind sys_timer64 sys_timer64_chk #(.MATCH_CH(MATCH_CH), .WDOG_CH(WDOG_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .cnt_wr       (cnt_wr),
   .cnt_wr_lo    (cnt_wr_lo),
   .bus_wdata    (bus_wdata),
   .count        (count),
   .adv          (adv),
   .evt          (evt),
   .status_q     (status_q),
   .status_wr    (status_wr),
   .latch_we     (latch_we),
   .latched_q    (latched_q),
   .irq          (irq),
   .wdog_rst_req (wdog_rst_req)
);

// File: tb/sys_timer64_test.sv
`timescale 1ns/1ps
module sys_timer64_test;
   localparam logic [7:0] A_LO  = 8'h00, A_HI  = 8'h04, A_M0  = 8'h08,
                          A_ST  = 8'h20, A_IE  = 8'h24, A_WD  = 8'h28,
                          A_DIV = 8'h2C, A_LAT = 8'h30, A_LL  = 8'h34,
                          A_LH  = 8'h38, A_NONE = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        wdog_rst_req;

   int total = 0;
   int bad = 0;
   int wd_pulses = 0;

   always #2.5 clk = ~clk;

   sys_timer64 uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .wdog_rst_req(wdog_rst_req)
   );

   always @(negedge clk) if (wdog_rst_req) wd_pulses++;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic snap(output logic [63:0] v);
      logic [31:0] h, l;
      wr(A_LAT, 32'h1);
      rd(A_LH, h);
      rd(A_LL, l);
      v = {h, l};
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #1ms;
      total++; bad++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] r, r2;
      logic [63:0] v, v2;
      int p0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_DIV, r); check("R1 div", r, 0);
      rd(A_ST, r);  check("R1 status", r, 0);
      rd(A_IE, r);  check("R1 int enable", r, 0);
      rd(A_WD, r);  check("R1 wdog arm", r, 0);
      rd(A_HI, r);  check("R1 counter high", r, 0);
      for (int i = 0; i < 6; i++) begin
         rd(A_M0 + 8'(4*i), r); check("R1 compare", r, 0);
      end
      check("R1 irq", irq, 0);
      check("R1 wdog req", wdog_rst_req, 0);
      // R9 unmapped and R3 command read as zero
      rd(A_NONE, r); check("R9 unmapped", r, 0);
      rd(A_LAT, r);  check("R3 command reads zero", r, 0);

      // R2 sweep: divider x wait length, snapshot after n+1 edges
      for (int d = 0; d < 4; d++) begin
         for (int n = 0; n < 10; n++) begin
            wr(A_DIV, d);
            wr(A_HI, 0);
            wr(A_LO, 32'h100);
            repeat (n) @(negedge clk);
            snap(v);
            check("R2 count", v, 64'h100 + 64'((n + 1) / (2 * (d + 1))));
         end
      end

      // R4 preset both halves
      wr(A_DIV, 0);
      wr(A_HI, 32'hABCD);
      wr(A_LO, 32'h7);
      snap(v);
      check("R4 preset", v, 64'h0000ABCD_00000007);
      rd(A_HI, r); check("R4 live high", r, 32'hABCD);

      // R2 carry into high; R5 wrap to zero fires all zero compares
      wr(A_ST, 32'h3F);
      wr(A_HI, 32'h5);
      wr(A_LO, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
      snap(v);
      check("R2 carry", v, 64'h00000006_00000000);
      rd(A_ST, r); check("R5 wrap matches", r, 32'h3F);

      // R6 write-one-to-clear
      wr(A_ST, 32'h0);  rd(A_ST, r); check("R6 zero write keeps", r, 32'h3F);
      wr(A_ST, 32'h2);  rd(A_ST, r); check("R6 clear bit1", r, 32'h3D);
      wr(A_ST, 32'h3F); rd(A_ST, r); check("R6 clear all", r, 0);

      // R3 snapshot holds while counter runs
      rd(A_LL, r); rd(A_LH, r2);
      repeat (20) @(negedge clk);
      rd(A_LL, v[31:0]); rd(A_LH, v[63:32]);
      check("R3 snapshot stable", v, {r2, r});
      rd(A_LO, r); check("R3 live differs", (r != v[31:0]), 1);

      // R5 cycle-exact set, no re-set while holding
      wr(A_M0, 32'h203);
      wr(A_DIV, 1);
      wr(A_HI, 0);
      wr(A_LO, 32'h200);
      repeat (12) @(negedge clk);
      rd(A_ST, r); check("R5 not before step+1", r, 0);
      @(negedge clk);
      rd(A_ST, r); check("R5 set after step", r, 1);
      check("R7 irq masked", irq, 0);
      wr(A_ST, 32'h1);
      rd(A_ST, r); check("R5 hold no re-set", r, 0);
      repeat (6) @(negedge clk);
      rd(A_ST, r); check("R5 no repeat", r, 0);

      // R5/R7 per-channel sweep, watchdog disarmed (R8)
      p0 = wd_pulses;
      for (int ch = 0; ch < 6; ch++) begin
         for (int k = 0; k < 6; k++) wr(A_M0 + 8'(4*k), 32'hDEAD0000);
         wr(A_M0 + 8'(4*ch), 32'h302);
         wr(A_IE, 0);
         wr(A_ST, 32'h3F);
         wr(A_DIV, 0);
         wr(A_HI, 0);
         wr(A_LO, 32'h300);
         repeat (8) @(negedge clk);
         rd(A_ST, r); check("R5 single channel", r, 32'(1 << ch));
         check("R7 no enable", irq, 0);
         wr(A_IE, 32'(~(1 << ch) & 6'h3F));
         #1; check("R7 other enables", irq, 0);
         wr(A_IE, 32'(1 << ch));
         #1; check("R7 own enable", irq, 1);
         wr(A_ST, 32'(1 << ch));
         #1; check("R7 cleared", irq, 0);
      end
      check("R8 disarmed no pulse", wd_pulses - p0, 0);

      // R8 armed watchdog, one-cycle pulse with status 5
      wr(A_WD, 1);
      for (int k = 0; k < 6; k++) wr(A_M0 + 8'(4*k), 32'hDEAD0000);
      wr(A_M0 + 8'h14, 32'h402);
      wr(A_ST, 32'h3F);
      wr(A_DIV, 0);
      wr(A_HI, 0);
      p0 = wd_pulses;
      wr(A_LO, 32'h400);
      repeat (4) @(negedge clk);
      #1; check("R8 before match", wdog_rst_req, 0);
      @(negedge clk);
      #1; check("R8 pulse", wdog_rst_req, 1);
      rd(A_ST, r); check("R8 status5", r, 32'h20);
      @(negedge clk);
      #1; check("R8 pulse ends", wdog_rst_req, 0);
      repeat (10) @(negedge clk);
      check("R8 single pulse", wd_pulses - p0, 1);

      finish_run();
   end
endmodule